// File: doc/BRIEF.md
# Block-Section Train Sequencer

This block is a synchronous controller that steers a single train around a loop of powered track sections and brings it to a timed halt at a station. Contact sensors report, as one-cycle pulses, when the train passes the entry sensor or the exit sensor of a section. The block drives a registered power mode and speed for every section, a red or green aspect for every signal, and a set of point positions. A once-per-second tick pulse times the stop at the station.

Three segments around the station are shared with other traffic. Before a move that needs them, the block raises request lines to an external lock arbiter. It moves on in the same cycle when every grant it needs is already held. Otherwise it brakes where it stands and waits for the grants. Power is withdrawn from each section once the train has cleared it, and each request is dropped at a fixed point of the run. The number of plain line sections, the stop length in ticks and the point settings for the arrival and departure routes are parameters.

Section indices are fixed by the parameter `N_LINE`. Line sections are 0 to `N_LINE-1`, in running order. The station approach is `N_LINE`, the station is `N_LINE+1`, and the station exit segment is `N_LINE+2`.

Top module: `train_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, every signal is red (0), every section has power mode off with speed 0, all points are straight (0) and all requests are low. After release, the first clock edge raises the station and exit requests and starts the departure.
- R2: Each line section and the station go through three phases. The first pulse of a section's entry contact selects "enter", which changes no output. A second pulse of the same entry contact selects "travel". The section's exit contact then selects "leave" (for the station, it selects the dwell).
- R3: On entering the leave phase of a line section, that section's signal turns green, and the section and the next one are powered forward at speed 100. On leaving the phase, the signal returns to red. At most one signal is green at any time.
- R4: On entering a travel phase, the section the train has just left is powered off. For line section 0, that section is the exit segment.
- R5: The station entry contact sets the last line section off and sets the approach and station sections to forward at speed 40. The station exit contact sets the station section to brake with speed 0.
- R6: While braked at the station, tick pulses are counted. The train departs on the clock edge that takes the `DWELL_TICKS`-th tick (5 by default). Ticks that arrive before the dwell begins are not counted.
- R7: Request bits are: bit 0 approach, bit 1 station, bit 2 exit. The exit contact of the last line section raises bits 0 and 1. The end of the dwell, or the first edge after reset, raises bits 1 and 2. If the matching grants (both approach and station for arrival, exit for departure) are high in that cycle, the move happens at once. Otherwise the current section brakes with speed 0 and its signal stays red until the grants are present.
- R8: The approach request drops on entering the station travel phase. The station request drops when the departure phase is left. The exit request drops on entering the travel phase of line section 0.
- R9: On departure, the points in `DEP_PT_SET` take the values in `DEP_PT_VAL`. On arrival (leave of the last line section), the points in `ARR_PT_SET` take the values in `ARR_PT_VAL`. A value of 1 means branch. Points outside a set keep their value.
- R10: A contact pulse that is not the one the current phase waits for changes no output.
- R11: Power mode is 2 bits per section: 0 off, 1 forward, 2 reverse, 3 brake. Speed is 7 bits per section. All outputs change on the same clock edge as the phase transition that causes them. A section that is off or braked has speed 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| entry_i | input | N_LINE+3 | Entry contact pulse per section |
| exit_i | input | N_LINE+3 | Exit contact pulse per section |
| tick_i | input | 1 | Once-per-second tick pulse |
| grant_i | input | 3 | Lock grants: approach, station, exit |
| signal_o | output | N_LINE+3 | Signal aspect per section, 1 = green |
| pwr_mode_o | output | 2*(N_LINE+3) | Power mode per section, 2 bits each |
| speed_o | output | 7*(N_LINE+3) | Speed per section, 7 bits each |
| point_o | output | N_PT | Point positions, 1 = branch |
| req_o | output | 3 | Lock requests: approach, station, exit |

## Verification
The bench covers both ways past a lock. Departure first waits for a missing exit grant, and a later departure proceeds at once. A design that ignored grants would give a green signal while the segment belongs to someone else; one that checked grants only after a wait cycle would lose the immediate path. Double entry pulses are driven and checked after each pulse, so a design that jumped straight to travel would switch power off one pulse early. A tick is injected before the dwell starts, and the count is checked tick by tick, so an off-by-one or a counter that runs outside the dwell shows as an early or late departure. Stray contacts from other sections are driven during departure and must leave every output unchanged.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_FWD   = 2'd1,
    PM_REV   = 2'd2,
    PM_BRAKE = 2'd3
  } pmode_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WAIT_DEP,
    PH_DEPART,
    PH_ENTER,
    PH_TRAVEL,
    PH_LEAVE,
    PH_WAIT_ARR,
    PH_STN_ENTER,
    PH_STN_TRAVEL,
    PH_DWELL
  } phase_e;

  localparam int NUM_SEG  = 3;
  localparam int SEG_APP  = 0;
  localparam int SEG_STN  = 1;
  localparam int SEG_EXIT = 2;
  localparam int SPD_W    = 7;
  localparam logic [SPD_W-1:0] SPD_FULL = 7'd100;
  localparam logic [SPD_W-1:0] SPD_SLOW = 7'd40;
endpackage

// File: rtl/tsq_dwell_timer.sv
module tsq_dwell_timer #(
  parameter int DWELL_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(DWELL_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == CNT_W'(DWELL_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsq_phase_fsm.sv
module tsq_phase_fsm
  import tsq_pkg::*;
#(
  parameter int N_LINE = 4,
  localparam int N_SEC = N_LINE + 3,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SEC-1:0] entry_i,
  input  logic [N_SEC-1:0] exit_i,
  input  logic             arr_ok_i,
  input  logic             dep_ok_i,
  input  logic             dwell_done_i,
  output phase_e           phase_q_o,
  output logic [SEC_W-1:0] idx_q_o,
  output phase_e           phase_d_o,
  output logic [SEC_W-1:0] idx_d_o,
  output logic             move_o
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(N_LINE - 1);
  localparam logic [SEC_W-1:0] STN  = SEC_W'(N_LINE + 1);

  phase_e           phase_q, phase_d;
  logic [SEC_W-1:0] idx_q, idx_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    case (phase_q)
      PH_IDLE:     phase_d = dep_ok_i ? PH_DEPART : PH_WAIT_DEP;
      PH_WAIT_DEP: if (dep_ok_i) phase_d = PH_DEPART;
      PH_DEPART: if (entry_i[0]) begin
        phase_d = PH_ENTER;
        idx_d   = '0;
      end
      PH_ENTER:  if (entry_i[idx_q]) phase_d = PH_TRAVEL;
      PH_TRAVEL: if (exit_i[idx_q]) begin
        if (idx_q == LAST) phase_d = arr_ok_i ? PH_LEAVE : PH_WAIT_ARR;
        else               phase_d = PH_LEAVE;
      end
      PH_LEAVE: begin
        if (idx_q == LAST) begin
          if (entry_i[STN]) phase_d = PH_STN_ENTER;
        end else if (entry_i[idx_q + 1'b1]) begin
          phase_d = PH_ENTER;
          idx_d   = idx_q + 1'b1;
        end
      end
      PH_WAIT_ARR:   if (arr_ok_i) phase_d = PH_LEAVE;
      PH_STN_ENTER:  if (entry_i[STN]) phase_d = PH_STN_TRAVEL;
      PH_STN_TRAVEL: if (exit_i[STN]) phase_d = PH_DWELL;
      PH_DWELL:      if (dwell_done_i) phase_d = dep_ok_i ? PH_DEPART : PH_WAIT_DEP;
      default:       phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign move_o    = (phase_d != phase_q) || (idx_d != idx_q);
  assign phase_q_o = phase_q;
  assign idx_q_o   = idx_q;
  assign phase_d_o = phase_d;
  assign idx_d_o   = idx_d;
endmodule

// File: rtl/tsq_out_bank.sv
module tsq_out_bank
  import tsq_pkg::*;
#(
  parameter int N_LINE = 4,
  parameter int N_PT   = 6,
  parameter logic [N_PT-1:0] DEP_PT_SET = 6'b000111,
  parameter logic [N_PT-1:0] DEP_PT_VAL = 6'b000011,
  parameter logic [N_PT-1:0] ARR_PT_SET = 6'b111000,
  parameter logic [N_PT-1:0] ARR_PT_VAL = 6'b110000,
  localparam int N_SEC = N_LINE + 3,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  phase_e                 phase_q_i,
  input  logic [SEC_W-1:0]       idx_q_i,
  input  phase_e                 phase_d_i,
  input  logic [SEC_W-1:0]       idx_d_i,
  input  logic                   move_i,
  output logic [N_SEC-1:0]       signal_o,
  output logic [2*N_SEC-1:0]     pwr_mode_o,
  output logic [SPD_W*N_SEC-1:0] speed_o,
  output logic [N_PT-1:0]        point_o,
  output logic [NUM_SEG-1:0]     req_o
);
  localparam logic [SEC_W-1:0] LAST = SEC_W'(N_LINE - 1);
  localparam int APP  = N_LINE;
  localparam int STN  = N_LINE + 1;
  localparam int EXTS = N_LINE + 2;

  logic   [N_SEC-1:0]   sig_q, sig_n;
  pmode_e               pwr_q [N_SEC];
  pmode_e               pwr_n [N_SEC];
  logic   [SPD_W-1:0]   spd_q [N_SEC];
  logic   [SPD_W-1:0]   spd_n [N_SEC];
  logic   [N_PT-1:0]    pts_q, pts_n;
  logic   [NUM_SEG-1:0] req_q, req_n;

  // exit actions of the old phase, then entry actions of the new one
  always_comb begin
    sig_n = sig_q;
    pwr_n = pwr_q;
    spd_n = spd_q;
    pts_n = pts_q;
    req_n = req_q;
    if (move_i) begin
      case (phase_q_i)
        PH_IDLE, PH_DWELL: begin
          req_n[SEG_STN]  = 1'b1;
          req_n[SEG_EXIT] = 1'b1;
        end
        PH_DEPART: begin
          pwr_n[STN]     = PM_OFF;
          spd_n[STN]     = '0;
          req_n[SEG_STN] = 1'b0;
          sig_n[STN]     = 1'b0;
        end
        PH_TRAVEL: if (idx_q_i == LAST) begin
          req_n[SEG_APP] = 1'b1;
          req_n[SEG_STN] = 1'b1;
        end
        PH_LEAVE: sig_n[idx_q_i] = 1'b0;
        default: ;
      endcase

      case (phase_d_i)
        PH_WAIT_DEP: begin
          pwr_n[STN] = PM_BRAKE;
          spd_n[STN] = '0;
        end
        PH_DEPART: begin
          sig_n       = sig_n | (N_SEC'(1) << STN);
          pts_n       = (pts_n & ~DEP_PT_SET) | (DEP_PT_VAL & DEP_PT_SET);
          pwr_n[STN]  = PM_FWD;
          spd_n[STN]  = SPD_FULL;
          pwr_n[EXTS] = PM_FWD;
          spd_n[EXTS] = SPD_FULL;
          pwr_n[0]    = PM_FWD;
          spd_n[0]    = SPD_FULL;
        end
        PH_TRAVEL: begin
          if (idx_d_i == '0) begin
            pwr_n[EXTS]     = PM_OFF;
            spd_n[EXTS]     = '0;
            req_n[SEG_EXIT] = 1'b0;
          end else begin
            pwr_n[idx_d_i - 1'b1] = PM_OFF;
            spd_n[idx_d_i - 1'b1] = '0;
          end
        end
        PH_LEAVE: begin
          sig_n[idx_d_i] = 1'b1;
          pwr_n[idx_d_i] = PM_FWD;
          spd_n[idx_d_i] = SPD_FULL;
          if (idx_d_i == LAST) begin
            pwr_n[APP] = PM_FWD;
            spd_n[APP] = SPD_FULL;
            pwr_n[STN] = PM_FWD;
            spd_n[STN] = SPD_FULL;
            pts_n      = (pts_n & ~ARR_PT_SET) | (ARR_PT_VAL & ARR_PT_SET);
          end else begin
            pwr_n[idx_d_i + 1'b1] = PM_FWD;
            spd_n[idx_d_i + 1'b1] = SPD_FULL;
          end
        end
        PH_WAIT_ARR: begin
          pwr_n[LAST] = PM_BRAKE;
          spd_n[LAST] = '0;
        end
        PH_STN_ENTER: begin
          pwr_n[LAST] = PM_OFF;
          spd_n[LAST] = '0;
          pwr_n[APP]  = PM_FWD;
          spd_n[APP]  = SPD_SLOW;
          pwr_n[STN]  = PM_FWD;
          spd_n[STN]  = SPD_SLOW;
        end
        PH_STN_TRAVEL: begin
          pwr_n[APP]     = PM_OFF;
          spd_n[APP]     = '0;
          req_n[SEG_APP] = 1'b0;
        end
        PH_DWELL: begin
          pwr_n[STN] = PM_BRAKE;
          spd_n[STN] = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= '0;
      pts_q <= '0;
      req_q <= '0;
      for (int k = 0; k < N_SEC; k++) begin
        pwr_q[k] <= PM_OFF;
        spd_q[k] <= '0;
      end
    end else begin
      sig_q <= sig_n;
      pts_q <= pts_n;
      req_q <= req_n;
      pwr_q <= pwr_n;
      spd_q <= spd_n;
    end
  end

  for (genvar g = 0; g < N_SEC; g++) begin : g_flat
    assign pwr_mode_o[2*g +: 2]     = pwr_q[g];
    assign speed_o[SPD_W*g +: SPD_W] = spd_q[g];
  end

  assign signal_o = sig_q;
  assign point_o  = pts_q;
  assign req_o    = req_q;
endmodule

// File: rtl/train_seq_ctrl.sv
module train_seq_ctrl
  import tsq_pkg::*;
#(
  parameter int N_LINE      = 4,
  parameter int N_PT        = 6,
  parameter int DWELL_TICKS = 5,
  parameter logic [N_PT-1:0] DEP_PT_SET = 6'b000111,
  parameter logic [N_PT-1:0] DEP_PT_VAL = 6'b000011,
  parameter logic [N_PT-1:0] ARR_PT_SET = 6'b111000,
  parameter logic [N_PT-1:0] ARR_PT_VAL = 6'b110000,
  localparam int N_SEC = N_LINE + 3,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SEC-1:0]       entry_i,
  input  logic [N_SEC-1:0]       exit_i,
  input  logic                   tick_i,
  input  logic [2:0]             grant_i,
  output logic [N_SEC-1:0]       signal_o,
  output logic [2*N_SEC-1:0]     pwr_mode_o,
  output logic [7*N_SEC-1:0]     speed_o,
  output logic [N_PT-1:0]        point_o,
  output logic [2:0]             req_o
);
  phase_e           phase_q, phase_d;
  logic [SEC_W-1:0] idx_q, idx_d;
  logic             move, dwell_done, arr_ok, dep_ok;

  assign arr_ok = grant_i[SEG_APP] && grant_i[SEG_STN];
  assign dep_ok = grant_i[SEG_EXIT];

  tsq_phase_fsm #(.N_LINE(N_LINE)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .entry_i      (entry_i),
    .exit_i       (exit_i),
    .arr_ok_i     (arr_ok),
    .dep_ok_i     (dep_ok),
    .dwell_done_i (dwell_done),
    .phase_q_o    (phase_q),
    .idx_q_o      (idx_q),
    .phase_d_o    (phase_d),
    .idx_d_o      (idx_d),
    .move_o       (move)
  );

  tsq_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_q == PH_DWELL),
    .tick_i (tick_i),
    .done_o (dwell_done)
  );

  tsq_out_bank #(
    .N_LINE     (N_LINE),
    .N_PT       (N_PT),
    .DEP_PT_SET (DEP_PT_SET),
    .DEP_PT_VAL (DEP_PT_VAL),
    .ARR_PT_SET (ARR_PT_SET),
    .ARR_PT_VAL (ARR_PT_VAL)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_q_i  (phase_q),
    .idx_q_i    (idx_q),
    .phase_d_i  (phase_d),
    .idx_d_i    (idx_d),
    .move_i     (move),
    .signal_o   (signal_o),
    .pwr_mode_o (pwr_mode_o),
    .speed_o    (speed_o),
    .point_o    (point_o),
    .req_o      (req_o)
  );
endmodule

// File: rtl/train_seq_chk.sv
module train_seq_chk #(
  parameter int N_LINE = 4,
  localparam int N_SEC = N_LINE + 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         grant_i,
  input logic [N_SEC-1:0]   signal_o,
  input logic [2*N_SEC-1:0] pwr_mode_o,
  input logic [7*N_SEC-1:0] speed_o,
  input logic [2:0]         req_o
);
  localparam int LAST = N_LINE - 1;
  localparam int STN  = N_LINE + 1;
  localparam int EXTS = N_LINE + 2;

  assert_one_green_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(signal_o));

  assert_arr_granted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(signal_o[LAST]) |-> $past(grant_i[0] && grant_i[1]));

  assert_dep_granted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(signal_o[STN]) |-> $past(grant_i[2]));

  assert_exit_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o[2]) |-> (pwr_mode_o[2*EXTS +: 2] == 2'd0));

  for (genvar g = 0; g < N_SEC; g++) begin : g_spd
    assert_idle_speed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwr_mode_o[2*g +: 2] == 2'd0 || pwr_mode_o[2*g +: 2] == 2'd3)
        |-> (speed_o[7*g +: 7] == 7'd0));
  end
endmodule

bind train_seq_ctrl train_seq_chk #(.N_LINE(N_LINE)) u_chk (.*);

// File: tb/train_seq_ctrl_test.sv
module train_seq_ctrl_test;
  localparam int NL  = 3;
  localparam int NS  = NL + 3;
  localparam int NP  = 6;
  localparam int DW  = 5;
  localparam int APP = NL;
  localparam int STN = NL + 1;
  localparam int EXT = NL + 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NS-1:0]   entry = '0;
  logic [NS-1:0]   exitc = '0;
  logic            tick = 1'b0;
  logic [2:0]      grant = '0;
  logic [NS-1:0]   signal_o;
  logic [2*NS-1:0] pwr_mode_o;
  logic [7*NS-1:0] speed_o;
  logic [NP-1:0]   point_o;
  logic [2:0]      req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  train_seq_ctrl #(
    .N_LINE(NL), .N_PT(NP), .DWELL_TICKS(DW),
    .DEP_PT_SET(6'b000111), .DEP_PT_VAL(6'b000011),
    .ARR_PT_SET(6'b111000), .ARR_PT_VAL(6'b110000)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .entry_i(entry), .exit_i(exitc),
    .tick_i(tick), .grant_i(grant), .signal_o(signal_o),
    .pwr_mode_o(pwr_mode_o), .speed_o(speed_o), .point_o(point_o), .req_o(req_o)
  );

  function automatic int md(int k);
    return int'(pwr_mode_o[2*k +: 2]);
  endfunction
  function automatic int sp(int k);
    return int'(speed_o[7*k +: 7]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_en(int k);
    entry[k] = 1'b1; @(negedge clk); entry[k] = 1'b0;
  endtask
  task automatic pulse_ex(int k);
    exitc[k] = 1'b1; @(negedge clk); exitc[k] = 1'b0;
  endtask
  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", "signals", int'(signal_o), 0);
    chk("R1", "power", int'(pwr_mode_o), 0);
    chk("R1", "speed", int'(speed_o != '0), 0);
    chk("R1", "points", int'(point_o), 0);
    chk("R1", "requests", int'(req_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_depart_wait();
    step(1);
    chk("R1", "req after first edge", int'(req_o), 6);
    chk("R7", "station brake while waiting", md(STN), 3);
    chk("R7", "signal red while waiting", int'(signal_o), 0);
    step(3);
    chk("R7", "still waiting", int'(signal_o), 0);
    grant = 3'b100;
    step(1);
    chk("R11", "station green same edge", int'(signal_o), 1 << STN);
    chk("R9", "departure points", int'(point_o), 6'b000011);
    chk("R3", "station fwd", md(STN), 1);
    chk("R3", "exit seg fwd", md(EXT), 1);
    chk("R3", "line0 speed", sp(0), 100);
  endtask

  task automatic t_ignore();
    pulse_ex(1);
    pulse_en(2);
    pulse_en(STN);
    chk("R10", "signal unchanged", int'(signal_o), 1 << STN);
    chk("R10", "req unchanged", int'(req_o), 6);
    chk("R10", "station power unchanged", md(STN), 1);
  endtask

  task automatic t_line();
    pulse_en(0);
    chk("R3", "station signal red", int'(signal_o), 0);
    chk("R8", "station req dropped", int'(req_o), 4);
    chk("R2", "exit seg kept on enter", md(EXT), 1);
    pulse_en(0);
    chk("R4", "exit seg off on travel", md(EXT), 0);
    chk("R8", "exit req dropped", int'(req_o), 0);
    pulse_ex(0);
    chk("R3", "line0 green", int'(signal_o), 1);
    chk("R3", "line1 fwd", md(1), 1);
    chk("R3", "line1 speed", sp(1), 100);
    pulse_en(1);
    chk("R3", "line0 red on exit", int'(signal_o), 0);
    chk("R2", "line0 kept on enter", md(0), 1);
    pulse_en(1);
    chk("R4", "line0 off", md(0), 0);
    pulse_ex(1);
    chk("R3", "line1 green", int'(signal_o), 2);
    chk("R3", "line2 fwd", md(2), 1);
    pulse_en(2);
    pulse_en(2);
    chk("R4", "line1 off", md(1), 0);
  endtask

  task automatic t_arrive_wait();
    grant = 3'b001;
    pulse_ex(2);
    chk("R7", "arrival requests", int'(req_o), 3);
    chk("R7", "line2 brake", md(2), 3);
    chk("R7", "line2 speed 0", sp(2), 0);
    chk("R7", "signal red", int'(signal_o), 0);
    step(2);
    chk("R7", "still red", int'(signal_o), 0);
    grant = 3'b011;
    step(1);
    chk("R7", "line2 green after grant", int'(signal_o), 4);
    chk("R3", "approach fwd", md(APP), 1);
    chk("R3", "station speed", sp(STN), 100);
    chk("R9", "arrival points", int'(point_o), 6'b110011);
  endtask

  task automatic t_station();
    pulse_en(STN);
    chk("R5", "line2 off", md(2), 0);
    chk("R5", "approach slow", sp(APP), 40);
    chk("R5", "station slow", sp(STN), 40);
    chk("R3", "signals red", int'(signal_o), 0);
    pulse_tick(); // not in dwell yet
    pulse_en(STN);
    chk("R8", "approach req dropped", int'(req_o), 2);
    chk("R2", "approach off on travel", md(APP), 0);
    pulse_ex(STN);
    chk("R5", "station brake", md(STN), 3);
    chk("R5", "station speed 0", sp(STN), 0);
  endtask

  task automatic t_dwell();
    grant = 3'b111;
    for (int i = 1; i < DW; i++) begin
      pulse_tick();
      step(1);
      chk("R6", "still dwelling", int'(signal_o), 0);
      chk("R6", "still braked", md(STN), 3);
    end
    pulse_tick();
    chk("R6", "departs on last tick", int'(signal_o), 1 << STN);
    chk("R7", "immediate departure reqs", int'(req_o), 6);
    chk("R7", "station fwd", md(STN), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_depart_wait();
    t_ignore();
    t_line();
    t_arrive_wait();
    t_station();
    t_dwell();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule